// File: doc/BRIEF.md
# USB Endpoint Handshake Response Controller

This block chooses the handshake that a full-speed USB device function sends back to the host for three kinds of decoded token: an IN on the bulk transmit endpoint (endpoint 4), an OUT on the bulk receive endpoint (endpoint 3), and a descriptor read on the control endpoint. It looks at FIFO status, a small control register and an active-low end-of-transfer input from the DMA engine. For each token it returns one of four codes: data ACK, zero-length-packet ACK, NAK or STALL. The packet engine then serializes that answer.

End of transfer can be signalled in two ways. Software can set a sticky bit, or the DMA engine can pull its input low. Either one turns the NAK that an empty transmit FIFO would otherwise give into an ACK carrying a zero-length packet. The software bit clears itself once that packet has been chosen. The CPU sees one 8-bit register through a write port and a combinational read port.

Top module: `usb_ep_handshake`

## Requirements
- R1: After reset, hs_valid and rx_discard are 0, and cpu_rdata equals dma_req shifted to bit 2 with all other bits 0.
- R2: For a token presented with tok_valid high, hs_valid is high for exactly one cycle, in the cycle after the token. hs_code then holds 0 for data ACK, 1 for zero-length ACK, 2 for NAK and 3 for STALL. tok_kind is 0 for an endpoint 4 IN, 1 for an endpoint 3 OUT, 2 for a descriptor read and 3 for a token this block ignores; a kind 3 token produces no hs_valid.
- R3: An endpoint 4 IN while the endpoint 4 stall bit (bit 4) is set gets STALL, whatever the FIFO and end-of-transfer state.
- R4: An endpoint 4 IN that is not stalled, with tx_empty low, gets data ACK.
- R5: An endpoint 4 IN that is not stalled, with tx_empty high, gets zero-length ACK if the software end-of-transfer bit (bit 6) is set or dma_eot_n is low.
- R6: An endpoint 4 IN that is not stalled, with tx_empty high, gets NAK if bit 6 is clear and dma_eot_n is high.
- R7: Bit 6 reads 0 after a token that drew a zero-length ACK, and is kept after any other answer. A CPU write of 0 to bit 6 also clears it.
- R8: A CPU write of 1 to bit 6 in the same cycle as a zero-length ACK decision leaves bit 6 set.
- R9: A descriptor read gets NAK while the enable bit (bit 5) is clear, and data ACK once it is set.
- R10: An endpoint 3 OUT while the endpoint 3 stall bit (bit 3) is set gets STALL, and rx_discard pulses high in the same cycle as hs_valid.
- R11: An endpoint 3 OUT that is not stalled gets NAK when rx_level + MAX_PKT exceeds FIFO_DEPTH, and data ACK otherwise.
- R12: Bits 6..3 of cpu_rdata read back the last written values. Bit 2 always mirrors dma_req and ignores writes. Bits 7, 1 and 0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | Decoded token present this cycle |
| tok_kind | input | 2 | Token kind: 0 EP4 IN, 1 EP3 OUT, 2 descriptor read, 3 ignored |
| tx_empty | input | 1 | Transmit FIFO empty |
| rx_level | input | $clog2(FIFO_DEPTH+1) | Bytes held in the receive FIFO |
| dma_eot_n | input | 1 | Active-low end-of-transfer from DMA |
| dma_req | input | 1 | Internal DMA request, mirrored in the register |
| cpu_we | input | 1 | Register write strobe |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data |
| hs_valid | output | 1 | Handshake decision valid |
| hs_code | output | 2 | Handshake choice |
| rx_discard | output | 1 | Drop the received packet |

## Verification
The bench builds the block with FIFO_DEPTH = 8 and MAX_PKT = 4. With those values every receive fill level from 0 to 8 can be swept, so the room boundary for OUT tokens falls inside the sweep, between levels 4 and 5. For IN tokens, the bench walks all sixteen combinations of stall, empty, software end-of-transfer and DMA end-of-transfer, and checks the register state left behind after each one. The same-cycle race between a CPU write and the self-clear is driven directly.

// File: rtl/usb_ep_handshake.sv
module usb_ep_handshake #(
  parameter int FIFO_DEPTH = 64,
  parameter int MAX_PKT    = 64,
  localparam int LW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tok_valid,
  input  logic [1:0]    tok_kind,
  input  logic          tx_empty,
  input  logic [LW-1:0] rx_level,
  input  logic          dma_eot_n,
  input  logic          dma_req,
  input  logic          cpu_we,
  input  logic [7:0]    cpu_wdata,
  output logic [7:0]    cpu_rdata,
  output logic          hs_valid,
  output logic [1:0]    hs_code,
  output logic          rx_discard
);
  localparam logic [1:0] K_IN = 2'd0, K_OUT = 2'd1, K_DESC = 2'd2, K_NONE = 2'd3;
  localparam logic [1:0] HS_ACK = 2'd0, HS_ZLP = 2'd1, HS_NAK = 2'd2, HS_STALL = 2'd3;

  logic sw_eot, usb_en, ep4_stall, ep3_stall;
  logic [1:0] resp;
  logic zlp_now, drop_now;
  logic no_room;

  assign no_room = ((LW+1)'(rx_level) + (LW+1)'(MAX_PKT)) > (LW+1)'(FIFO_DEPTH);
  assign cpu_rdata = {1'b0, sw_eot, usb_en, ep4_stall, ep3_stall, dma_req, 2'b00};

  always_comb begin
    resp     = HS_NAK;
    zlp_now  = 1'b0;
    drop_now = 1'b0;
    case (tok_kind)
      K_IN: begin
        if (ep4_stall)                  resp = HS_STALL;
        else if (!tx_empty)             resp = HS_ACK;
        else if (sw_eot || !dma_eot_n) begin
          resp    = HS_ZLP;
          zlp_now = tok_valid;
        end
      end
      K_OUT: begin
        if (ep3_stall) begin
          resp     = HS_STALL;
          drop_now = 1'b1;
        end else if (!no_room)          resp = HS_ACK;
      end
      K_DESC: if (usb_en)               resp = HS_ACK;
      default: resp = HS_NAK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_valid   <= 1'b0;
      hs_code    <= HS_NAK;
      rx_discard <= 1'b0;
    end else begin
      hs_valid   <= tok_valid && (tok_kind != K_NONE);
      hs_code    <= resp;
      rx_discard <= tok_valid && drop_now;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_eot    <= 1'b0;
      usb_en    <= 1'b0;
      ep4_stall <= 1'b0;
      ep3_stall <= 1'b0;
    end else if (cpu_we) begin
      sw_eot    <= cpu_wdata[6];
      usb_en    <= cpu_wdata[5];
      ep4_stall <= cpu_wdata[4];
      ep3_stall <= cpu_wdata[3];
    end else if (zlp_now) begin
      sw_eot    <= 1'b0;
    end
  end

  // R3
  a_r3_stall_first: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_kind == K_IN && ep4_stall) |=> (hs_valid && hs_code == HS_STALL));
  // R5
  a_r5_zlp_needs_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && hs_code == HS_ZLP) |-> $past(tx_empty));
  // R7
  a_r7_eot_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_kind == K_IN && !ep4_stall && tx_empty && sw_eot && !cpu_we) |=> !cpu_rdata[6]);
  // R8
  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_wdata[6]) |=> cpu_rdata[6]);
  // R9
  a_r9_desc_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_kind == K_DESC && !usb_en) |=> (hs_valid && hs_code == HS_NAK));
  // R10
  a_r10_discard_stall: assert property (@(posedge clk) disable iff (!rst_n)
    rx_discard |-> (hs_valid && hs_code == HS_STALL));
endmodule

// File: tb/sim_usb_ep_handshake.sv
module sim_usb_ep_handshake;
  localparam int DEPTH = 8, MAXP = 4, LW = $clog2(DEPTH + 1);
  logic clk = 0, rst_n = 0, tok_valid = 0, tx_empty = 1, dma_eot_n = 1, dma_req = 0, cpu_we = 0;
  logic [1:0] tok_kind = 0;
  logic [LW-1:0] rx_level = 0;
  logic [7:0] cpu_wdata = 0, cpu_rdata;
  logic hs_valid, rx_discard;
  logic [1:0] hs_code;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  usb_ep_handshake #(.FIFO_DEPTH(DEPTH), .MAX_PKT(MAXP)) u0 (
    .clk, .rst_n, .tok_valid, .tok_kind, .tx_empty, .rx_level, .dma_eot_n, .dma_req,
    .cpu_we, .cpu_wdata, .cpu_rdata, .hs_valid, .hs_code, .rx_discard);

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); cpu_we = 1; cpu_wdata = d;
    @(negedge clk); cpu_we = 0;
  endtask

  task automatic tok(logic [1:0] k);
    @(negedge clk); tok_valid = 1; tok_kind = k;
    @(negedge clk); tok_valid = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 hs_valid", hs_valid, 0);
    chk("R1 rx_discard", rx_discard, 0);
    chk("R1 rdata", cpu_rdata, 0);

    // R12 register layout
    wr(8'hFF);
    chk("R12 rdata all", cpu_rdata, 8'h78);
    dma_req = 1; #1;
    chk("R12 dma mirror", cpu_rdata, 8'h7C);
    wr(8'h00);
    chk("R12 bit2 ignores write", cpu_rdata, 8'h04);
    dma_req = 0;

    // R3..R7 IN sweep
    for (int c = 0; c < 16; c++) begin
      automatic int st = c & 1, emp = (c >> 1) & 1, sw = (c >> 2) & 1, dn = (c >> 3) & 1;
      automatic int exp = st ? 3 : (!emp ? 0 : ((sw || !dn) ? 1 : 2));
      wr(8'((sw << 6) | (st << 4)));
      tx_empty = emp[0]; dma_eot_n = dn[0];
      tok(2'd0);
      chk("R2 valid IN", hs_valid, 1);
      chk(st ? "R3 stall" : (!emp ? "R4 data" : (exp == 1 ? "R5 zlp" : "R6 nak")), hs_code, exp);
      chk("R7 sw_eot after", cpu_rdata[6], (exp == 1) ? 0 : sw);
      @(negedge clk);
      chk("R2 one-cycle pulse", hs_valid, 0);
    end
    dma_eot_n = 1;

    // R7 software clear by write 0
    wr(8'h40); wr(8'h00);
    chk("R7 write zero", cpu_rdata[6], 0);

    // R8 write wins over self clear
    wr(8'h40); tx_empty = 1;
    @(negedge clk); tok_valid = 1; tok_kind = 0; cpu_we = 1; cpu_wdata = 8'h40;
    @(negedge clk); tok_valid = 0; cpu_we = 0;
    chk("R8 zlp", hs_code, 1);
    chk("R8 bit kept", cpu_rdata[6], 1);

    // R9 descriptor gate
    wr(8'h00); tok(2'd2);
    chk("R9 disabled", hs_code, 2);
    wr(8'h20); tok(2'd2);
    chk("R9 enabled", hs_code, 0);

    // R2 ignored kind
    tok(2'd3);
    chk("R2 kind3 no valid", hs_valid, 0);

    // R10 R11 OUT sweep
    for (int s = 0; s < 2; s++) begin
      wr(8'(s << 3));
      for (int l = 0; l <= DEPTH; l++) begin
        rx_level = LW'(l);
        tok(2'd1);
        chk("R2 valid OUT", hs_valid, 1);
        if (s) begin
          chk("R10 stall", hs_code, 3);
          chk("R10 discard", rx_discard, 1);
        end else begin
          chk("R11 room", hs_code, (l + MAXP > DEPTH) ? 2 : 0);
          chk("R11 no discard", rx_discard, 0);
        end
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule